// File: doc/BRIEF.md
# Latched 4-to-16 line decoder

This block turns a binary select code into a one-of-sixteen selection on a vector of output lines. A register in front of the decoder holds the code. While the load enable is high the register follows the select input on every clock edge. When the load enable drops, the register keeps the last code it took, so the select bus can carry other traffic without moving the outputs.

The held code is decoded all the time. A blanking input overrides the decode without a register in the path and drives every line to its idle level. The held code survives blanking, so the earlier selection comes back as soon as blanking is released.

A compile-time parameter sets the output sense. Selected lines are driven high and idle lines low, or the whole vector is inverted. Typical uses are steering a single serial data bit to one of sixteen destinations, with the blanking input gating the data, and chip-select generation.

Top module: `latched_line_decoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, the held code is cleared to 0. After reset, and with `blank` low, line 0 is the selected line until a new code is loaded.
- R2: At each rising clock edge with `load_en` high, the held code takes the value of `sel_code`. The lines show that code from this edge onward, which is one cycle after the code was presented.
- R3: At rising edges with `load_en` low, the held code does not change. Changes on `sel_code` then have no effect on `lines`.
- R4: Held code value k (0 to 15, with bit 3 of `sel_code` the most significant) selects `lines[k]`. Code 0 selects `lines[0]` and code 15 selects `lines[15]`.
- R5: With `ACTIVE_LOW` = 0, the selected line is 1 and every other line is 0.
- R6: With `ACTIVE_LOW` = 1, `lines` is the bitwise inverse of the `ACTIVE_LOW` = 0 value: the selected line is 0 and every other line is 1.
- R7: While `blank` is 1, every line is at its idle level (0 when `ACTIVE_LOW` = 0, 1 when `ACTIVE_LOW` = 1) in the same cycle, whatever the code is. The held code is kept, and its selection returns when `blank` goes back to 0.
- R8: While `blank` is 0, exactly one line is at its active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the held code |
| sel_code | input | CODE_W (4) | Binary select code, most significant bit first |
| load_en | input | 1 | High: the held code follows `sel_code`; low: the held code is kept |
| blank | input | 1 | High: all lines are forced to their idle level, with no clock delay |
| lines | output | 2**CODE_W (16) | Decoded one-of-sixteen output lines |

## Verification
On every cycle the assertions check four things. Blanking forces the idle level. Exactly one line is active when the block is not blanked. A code loaded at one edge shows up on the lines after that edge. The lines stay still across an edge with the load enable low. They also check that line 0 is selected straight after reset. The bench scenarios cover the rest. They walk all sixteen codes on both polarity builds at once, compare the two outputs bit for bit, and change the select bus under a low load enable. They also show that the earlier selection comes back once blanking is lifted, which the per-cycle checks do not track.

// File: rtl/latched_line_decoder.sv
module latched_line_decoder #(
  parameter int CODE_W = 4,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int LINES = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] sel_code,
  input  logic              load_en,
  input  logic              blank,
  output logic [LINES-1:0]  lines
);

  logic [CODE_W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst)          held <= '0;
    else if (load_en) held <= sel_code;
  end

  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : g_line
      logic hit;
      assign hit = !blank && (held == CODE_W'(i));
      if (ACTIVE_LOW) begin : g_low
        assign lines[i] = ~hit;
      end else begin : g_high
        assign lines[i] = hit;
      end
    end
  endgenerate

endmodule

// File: rtl/latched_line_decoder_chk.sv
module latched_line_decoder_chk #(
  parameter int CODE_W = 4,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int LINES = 1 << CODE_W
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] sel_code,
  input logic              load_en,
  input logic              blank,
  input logic [LINES-1:0]  lines
);

  logic [LINES-1:0] norm;
  assign norm = ACTIVE_LOW ? ~lines : lines;

  AST_BLANK_IDLE: assert property (@(posedge clk) disable iff (rst)
    blank |-> (norm == '0)); // R7

  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    !blank |-> ($countones(norm) == 1)); // R8

  AST_RESET_LINE0: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !blank) |-> (norm == LINES'(1))); // R1

  AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (rst)
    ($past(load_en) && !$past(rst) && !blank) |-> (norm == (LINES'(1) << $past(sel_code)))); // R2

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
    (!$past(load_en) && !$past(rst) && !blank && !$past(blank)) |-> $stable(lines)); // R3

endmodule

bind latched_line_decoder latched_line_decoder_chk #(
  .CODE_W(CODE_W), .ACTIVE_LOW(ACTIVE_LOW)
) u_chk (
  .clk(clk), .rst(rst), .sel_code(sel_code),
  .load_en(load_en), .blank(blank), .lines(lines)
);

// File: tb/test_latched_line_decoder.sv
module test_latched_line_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  sel_code = 4'd0;
  logic        load_en = 1'b0;
  logic        blank = 1'b0;
  logic [15:0] lines_hi, lines_lo;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  latched_line_decoder #(.CODE_W(4), .ACTIVE_LOW(1'b0)) i_latched_line_decoder (
    .clk(clk), .rst(rst), .sel_code(sel_code), .load_en(load_en),
    .blank(blank), .lines(lines_hi));

  latched_line_decoder #(.CODE_W(4), .ACTIVE_LOW(1'b1)) i_latched_line_decoder_low (
    .clk(clk), .rst(rst), .sel_code(sel_code), .load_en(load_en),
    .blank(blank), .lines(lines_lo));

  function automatic logic [15:0] pick(input int code);
    return 16'(1) << code;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_both(input string req, input int code);
    chk({req, " high"}, lines_hi, pick(code));
    chk({req, " low"}, lines_lo, ~pick(code));
  endtask

  task automatic t_reset;
    rst = 1'b1; load_en = 1'b0; blank = 1'b0; sel_code = 4'd9;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_both("R1 reset selects line 0", 0);
    @(posedge clk); @(negedge clk);
    chk_both("R1 line 0 kept after reset", 0);
  endtask

  task automatic t_all_codes;
    for (int k = 0; k < 16; k++) begin
      sel_code = 4'(k); load_en = 1'b1;
      @(posedge clk); @(negedge clk);
      chk_both("R4 R5 code decode", k);
      chk("R6 inverse polarity", lines_lo, ~lines_hi);
      checks++;
      if ($countones(lines_hi) != 1) begin
        failures++;
        $display("FAIL R8 actual=%0d expected=1", $countones(lines_hi));
      end
    end
    load_en = 1'b0;
  endtask

  task automatic t_follow;
    load_en = 1'b1; sel_code = 4'd3;
    #1 chk_both("R2 no change before edge", 15);
    @(posedge clk); @(negedge clk);
    chk_both("R2 follow 3", 3);
    sel_code = 4'd12;
    @(posedge clk); @(negedge clk);
    chk_both("R2 follow 12", 12);
    load_en = 1'b0;
  endtask

  task automatic t_hold;
    load_en = 1'b1; sel_code = 4'd5;
    @(posedge clk); @(negedge clk);
    load_en = 1'b0; sel_code = 4'd9;
    @(posedge clk); @(negedge clk);
    chk_both("R3 hold after data 9", 5);
    sel_code = 4'd15;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_both("R3 hold after data 15", 5);
  endtask

  task automatic t_blank;
    blank = 1'b1;
    #1;
    chk("R7 blank high variant", lines_hi, 16'h0000);
    chk("R7 blank low variant", lines_lo, 16'hFFFF);
    sel_code = 4'd2;
    @(posedge clk); @(negedge clk);
    chk("R7 blank held with new data", lines_hi, 16'h0000);
    blank = 1'b0;
    #1;
    chk_both("R7 selection restored", 5);
    blank = 1'b1; load_en = 1'b1; sel_code = 4'd14;
    @(posedge clk); @(negedge clk);
    chk("R7 blank during load", lines_lo, 16'hFFFF);
    blank = 1'b0; load_en = 1'b0;
    #1;
    chk_both("R7 R2 load under blank kept", 14);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_all_codes();
    t_follow();
    t_hold();
    t_blank();
    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule